// File: doc/BRIEF.md
# Four-Channel Memory-Mapped Timer Unit

This block holds four independent 32-bit up-counting timers reached through one register window. Every timer owns a count, a mode and a compare register; the first two timers also own a hold register. Software reads and writes these registers through a simple synchronous port: address, write enable, read enable, write data, and registered read data.

A single tick strobe stands in for the prescaled time base. On every tick each timer looks at its mode bits. It may advance its count, raise its interrupt request, and return its count to zero. Timers 1 to 3 disarm themselves after firing, so they behave as one-shot timers. Timer 0 keeps firing on every tick while it is armed. Interrupt request bit i is meant to feed interrupt controller line 9+i.

An access to a hold register that does not exist (timer 2 or 3) pulses an error strobe. The access itself is dropped.

Top module: `timer_bank`

## Requirements
- R1: A synchronous active-high reset clears every count, mode, compare and hold register. It also drives rdata_o, err_o and all irq_o bits low.
- R2: Address decoding works as follows.
  - addr_i[12:11] selects the timer.
  - addr_i[10:0] selects the register within that timer: 0x000 count, 0x010 mode, 0x020 compare, 0x030 hold.
  - A write lands on the next clock edge.
  - A read with rd_en_i presents the data on rdata_o after the next clock edge and holds it until the next read.
  - Any other in-timer offset reads as 0 and ignores writes.
- R3: On a tick, a timer whose mode bit 7 (count-up enable) is set increments its count by one, wrapping from 0xFFFFFFFF to 0. Without a tick, or with bit 7 clear, the count does not change.
- R4: On a tick with mode bit 8 (compare enable) or bit 9 (overflow enable) set, the timer fires: irq_o[i] is high for exactly the one cycle after that edge. If mode bit 6 (zero return) is also set, the count becomes 0, overriding the increment.
- R5: When timer 1, 2 or 3 fires, it clears mode bit 8 and mode bit 11 (overflow flag) and leaves every other mode bit, bit 9 included, unchanged. Timer 0 never changes its own mode.
- R6: Only timers 0 and 1 have a hold register. A read or write of the hold offset of timer 2 or 3 drives err_o high for the one cycle after the access. Such a write is discarded, and such a read returns 0.
- R7: A count write in the same cycle as a tick wins over both the increment and the zero return. A mode write in the same cycle as a firing tick wins over the one-shot clear. The tick still fires, using the mode value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 13 | Register address: timer in [12:11], register offset in [10:0] |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| tick_i | input | 1 | Prescaled tick strobe, one cycle wide |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse after an access to a missing hold register |
| irq_o | output | 4 | Per-timer interrupt request pulses (bit i drives controller line 9+i) |

## Verification
The assertions rely on these input assumptions:
- rst is high from time zero until the first edges have passed.
- tick_i, wr_en_i and rd_en_i are clean single-cycle strobes.
- The address is stable whenever a strobe is high.

The bench drives every input on the falling edge, raises each strobe for exactly one cycle, and only combines a tick with a write in the two deliberate R7 priority cases. With these inputs, the one-cycle-after relations on count, mode, irq_o and err_o apply without ambiguity.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  // Mode bit positions
  localparam int MB_ZRET = 6;   // return count to zero on fire
  localparam int MB_CUE  = 7;   // count up on tick
  localparam int MB_CMPE = 8;   // compare enable (arms the timer)
  localparam int MB_OVFE = 9;   // overflow enable (arms the timer)
  localparam int MB_OVFF = 11;  // overflow flag

  // In-timer register offsets
  localparam int OFS_COUNT = 'h000;
  localparam int OFS_MODE  = 'h010;
  localparam int OFS_COMP  = 'h020;
  localparam int OFS_HOLD  = 'h030;

  typedef enum logic [2:0] {
    RK_COUNT,
    RK_MODE,
    RK_COMP,
    RK_HOLD,
    RK_NONE
  } reg_kind_e;

endpackage

// File: rtl/timer_bank_decode.sv
module timer_bank_decode
  import timer_bank_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int NUM_TIMERS  = 4,
  parameter int HOLD_TIMERS = 2
) (
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic                                  wr_en_i,
  input  logic                                  rd_en_i,
  output logic [$clog2(NUM_TIMERS)-1:0]         idx_o,
  output reg_kind_e                             kind_o,
  output logic [NUM_TIMERS-1:0]                 wr_cnt_o,
  output logic [NUM_TIMERS-1:0]                 wr_mode_o,
  output logic [NUM_TIMERS-1:0]                 wr_comp_o,
  output logic [NUM_TIMERS-1:0]                 wr_hold_o,
  output logic                                  hold_fault_o
);

  localparam int IDX_W = $clog2(NUM_TIMERS);
  localparam int OFS_W = ADDR_W - IDX_W;

  logic [OFS_W-1:0] ofs;

  always_comb begin
    ofs   = addr_i[OFS_W-1:0];
    idx_o = addr_i[ADDR_W-1:OFS_W];
    case (ofs)
      OFS_W'(OFS_COUNT): kind_o = RK_COUNT;
      OFS_W'(OFS_MODE):  kind_o = RK_MODE;
      OFS_W'(OFS_COMP):  kind_o = RK_COMP;
      OFS_W'(OFS_HOLD):  kind_o = RK_HOLD;
      default:           kind_o = RK_NONE;
    endcase
  end

  // A hold access to a timer without a hold register is a fault (R6)
  assign hold_fault_o = (wr_en_i | rd_en_i) && (kind_o == RK_HOLD) &&
                        (32'(idx_o) >= HOLD_TIMERS);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_strobe
    logic hit;
    assign hit          = wr_en_i && (idx_o == IDX_W'(i));
    assign wr_cnt_o[i]  = hit && (kind_o == RK_COUNT);
    assign wr_mode_o[i] = hit && (kind_o == RK_MODE);
    assign wr_comp_o[i] = hit && (kind_o == RK_COMP);
    if (i < HOLD_TIMERS) begin : g_has_hold
      assign wr_hold_o[i] = hit && (kind_o == RK_HOLD);
    end else begin : g_no_hold
      assign wr_hold_o[i] = 1'b0;
    end
  end

  // R2: at most one register of the bank receives a write strobe
  always_comb begin
    a_one_write_r2: assert ($countones({wr_cnt_o, wr_mode_o, wr_comp_o, wr_hold_o}) <= 1)
      else $error("more than one register strobed for a single write");
  end

endmodule

// File: rtl/timer_bank_chan.sv
module timer_bank_chan
  import timer_bank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit ONESHOT  = 1'b0,
  parameter bit HAS_HOLD = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_cnt_i,
  input  logic              wr_mode_i,
  input  logic              wr_comp_i,
  input  logic              wr_hold_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] comp_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] count_q, mode_q, comp_q;
  logic              irq_q;
  logic              armed, fire;

  assign armed = mode_q[MB_CMPE] | mode_q[MB_OVFE];
  assign fire  = tick_i & armed;

  // Count: a software write beats the zero return, which beats the increment
  always_ff @(posedge clk) begin
    if (rst)                        count_q <= '0;
    else if (wr_cnt_i)              count_q <= wdata_i;
    else if (fire && mode_q[MB_ZRET]) count_q <= '0;
    else if (tick_i && mode_q[MB_CUE]) count_q <= count_q + 1'b1;
  end

  // Mode: a software write beats the one-shot disarm
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr_mode_i) begin
      mode_q <= wdata_i;
    end else if (ONESHOT && fire) begin
      mode_q[MB_CMPE] <= 1'b0;
      mode_q[MB_OVFF] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            comp_q <= '0;
    else if (wr_comp_i) comp_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= fire;
  end

  if (HAS_HOLD) begin : g_hold
    logic [DATA_W-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (rst)            hold_q <= '0;
      else if (wr_hold_i) hold_q <= wdata_i;
    end
    assign hold_o = hold_q;
  end else begin : g_nohold
    logic unused_hold_wr;
    assign unused_hold_wr = wr_hold_i;
    assign hold_o = '0;
  end

  assign count_o = count_q;
  assign mode_o  = mode_q;
  assign comp_o  = comp_q;
  assign irq_o   = irq_q;

  // R3: a tick on an enabled, non-firing timer advances the count by one
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && mode_q[MB_CUE] && !armed && !wr_cnt_i) |=> (count_q == $past(count_q) + 1'b1))
    else $error("count did not advance on tick");

  // R3: without tick or write the count is stable
  p_count_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !wr_cnt_i) |=> $stable(count_q))
    else $error("count moved without a tick");

  // R4: an armed timer with zero return lands on zero
  p_zero_return_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && armed && mode_q[MB_ZRET] && !wr_cnt_i) |=> (count_q == '0))
    else $error("zero return failed");

  // R4: the request follows a firing tick, and only that
  p_irq_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && armed) |=> irq_q)
    else $error("irq missing after firing tick");
  p_irq_cause_r4: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && armed) |=> !irq_q)
    else $error("irq without firing tick");

  // R7: a count write always wins
  p_count_write_r7: assert property (@(posedge clk) disable iff (rst)
    wr_cnt_i |=> (count_q == $past(wdata_i)))
    else $error("count write lost");

  if (ONESHOT) begin : g_os_chk
    // R5: a one-shot timer disarms itself after firing
    p_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
      (fire && !wr_mode_i) |=> (!mode_q[MB_CMPE] && !mode_q[MB_OVFF] &&
                               mode_q[MB_OVFE] == $past(mode_q[MB_OVFE])))
      else $error("one-shot disarm wrong");
  end else begin : g_rep_chk
    // R5: a repeating timer keeps its mode
    p_repeat_r5: assert property (@(posedge clk) disable iff (rst)
      !wr_mode_i |=> $stable(mode_q))
      else $error("repeating timer changed its mode");
  end

endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 32,
  parameter int NUM_TIMERS    = 4,
  parameter int HOLD_TIMERS   = 2,
  parameter int ONESHOT_FIRST = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  tick_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  err_o,
  output logic [NUM_TIMERS-1:0] irq_o
);

  localparam int IDX_W = $clog2(NUM_TIMERS);
  localparam int OFS_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]      idx;
  reg_kind_e             kind;
  logic [NUM_TIMERS-1:0] wr_cnt, wr_mode, wr_comp, wr_hold;
  logic                  hold_fault;

  logic [DATA_W-1:0] cnt_a  [NUM_TIMERS];
  logic [DATA_W-1:0] mode_a [NUM_TIMERS];
  logic [DATA_W-1:0] comp_a [NUM_TIMERS];
  logic [DATA_W-1:0] hold_a [NUM_TIMERS];

  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              err_q;

  timer_bank_decode #(
    .ADDR_W      (ADDR_W),
    .NUM_TIMERS  (NUM_TIMERS),
    .HOLD_TIMERS (HOLD_TIMERS)
  ) u_decode (
    .addr_i       (addr_i),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .idx_o        (idx),
    .kind_o       (kind),
    .wr_cnt_o     (wr_cnt),
    .wr_mode_o    (wr_mode),
    .wr_comp_o    (wr_comp),
    .wr_hold_o    (wr_hold),
    .hold_fault_o (hold_fault)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
    timer_bank_chan #(
      .DATA_W   (DATA_W),
      .ONESHOT  (i >= ONESHOT_FIRST),
      .HAS_HOLD (i < HOLD_TIMERS)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .tick_i    (tick_i),
      .wdata_i   (wdata_i),
      .wr_cnt_i  (wr_cnt[i]),
      .wr_mode_i (wr_mode[i]),
      .wr_comp_i (wr_comp[i]),
      .wr_hold_i (wr_hold[i]),
      .count_o   (cnt_a[i]),
      .mode_o    (mode_a[i]),
      .comp_o    (comp_a[i]),
      .hold_o    (hold_a[i]),
      .irq_o     (irq_o[i])
    );
  end

  always_comb begin
    case (kind)
      RK_COUNT: rd_mux = cnt_a[idx];
      RK_MODE:  rd_mux = mode_a[idx];
      RK_COMP:  rd_mux = comp_a[idx];
      RK_HOLD:  rd_mux = hold_a[idx];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= hold_fault;
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R2: read data only changes after a read strobe
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o))
    else $error("read data changed without a read");

  // R6: an access to a missing hold register raises the error strobe
  p_hold_err_r6: assert property (@(posedge clk) disable iff (rst)
    ((wr_en_i || rd_en_i) && addr_i[OFS_W-1:0] == OFS_W'(OFS_HOLD) &&
     32'(addr_i[ADDR_W-1:OFS_W]) >= HOLD_TIMERS) |=> err_o)
    else $error("missing hold access not flagged");

  // R6: no access, no error
  p_no_err_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i || rd_en_i) |=> !err_o)
    else $error("spurious error strobe");

endmodule

// File: tb/tb_timer_bank.sv
module tb_timer_bank;

  localparam int CLK_PERIOD = 10;
  localparam int MB_ZRET = 6, MB_CUE = 7, MB_CMPE = 8, MB_OVFE = 9, MB_OVFF = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [3:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  timer_bank dut (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .wdata_i (wdata),
    .tick_i  (tick),
    .rdata_o (rdata),
    .err_o   (err),
    .irq_o   (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [12:0] ta(int t, int ofs);
    return {2'(t), 11'(ofs)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge
  task automatic wr(logic [12:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 rdata", rdata, 0);
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++) begin
        rd(ta(t, r * 16), v);
        chk("R1 reg", v, 0);
      end

    // R2/R6: write-read sweep over every register of every timer
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++) begin
        wr(ta(t, r * 16), 32'hA500_0000 | (t << 8) | r);
        if (r == 3) chk("R6 err after hold write", 32'(err), (t >= 2) ? 1 : 0);
      end
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++) begin
        rd(ta(t, r * 16), v);
        if (r == 3) begin
          chk("R6 err after hold read", 32'(err), (t >= 2) ? 1 : 0);
          chk("R6 hold readback", v, (t >= 2) ? 0 : (32'hA500_0000 | (t << 8) | r));
        end else begin
          chk("R2 readback", v, 32'hA500_0000 | (t << 8) | r);
        end
      end
    @(negedge clk);
    chk("R6 err is a single pulse", 32'(err), 0);

    // R2: unmapped offsets read zero and leave real registers alone
    wr(ta(1, 'h040), 32'hDEAD_BEEF);
    wr(ta(1, 'h008), 32'hDEAD_BEEF);
    rd(ta(1, 'h040), v); chk("R2 unmapped read", v, 0);
    for (int r = 0; r < 4; r++) begin
      rd(ta(1, r * 16), v);
      chk("R2 unmapped write ignored", v, 32'hA500_0100 | r);
    end

    // Disarm all timers
    for (int t = 0; t < 4; t++) wr(ta(t, 'h010), 0);

    // R3/R4/R5: exhaustive sweep of the four behaviour bits on every timer
    for (int t = 0; t < 4; t++)
      for (int c = 0; c < 16; c++) begin
        logic [31:0] m, st, ecnt, emode;
        logic        f;
        m  = (32'(c[0]) << MB_CUE) | (32'(c[1]) << MB_ZRET) |
             (32'(c[2]) << MB_CMPE) | (32'(c[3]) << MB_OVFE) |
             (32'd1 << MB_OVFF) | 32'h8;
        st = 32'h1000 * t + c * 3;
        f  = c[2] | c[3];
        ecnt  = (f && c[1]) ? 0 : (c[0] ? st + 1 : st);
        emode = (f && t > 0) ? (m & ~((32'd1 << MB_CMPE) | (32'd1 << MB_OVFF))) : m;
        wr(ta(t, 'h000), st);
        wr(ta(t, 'h010), m);
        tick1();
        chk("R4 irq on tick", 32'(irq), f ? (32'd1 << t) : 0);
        @(negedge clk);
        chk("R4 irq one cycle", 32'(irq), 0);
        rd(ta(t, 'h000), v); chk("R3/R4 count after tick", v, ecnt);
        rd(ta(t, 'h010), v); chk("R5 mode after tick", v, emode);
        wr(ta(t, 'h010), 0);
      end

    // R3: wrap around
    wr(ta(0, 'h000), 32'hFFFF_FFFF);
    wr(ta(0, 'h010), 32'd1 << MB_CUE);
    tick1();
    rd(ta(0, 'h000), v); chk("R3 wrap", v, 0);

    // R3: idle cycles do not count, ticks do
    wr(ta(2, 'h000), 5);
    wr(ta(2, 'h010), 32'd1 << MB_CUE);
    repeat (5) @(negedge clk);
    rd(ta(2, 'h000), v); chk("R3 no tick no count", v, 5);
    repeat (3) tick1();
    rd(ta(2, 'h000), v); chk("R3 three ticks", v, 8);
    wr(ta(2, 'h010), 0);
    wr(ta(0, 'h010), 0);

    // R5: timer 0 repeats, timer 1 fires once with compare enable
    wr(ta(0, 'h010), 32'd1 << MB_CMPE);
    wr(ta(1, 'h010), 32'd1 << MB_CMPE);
    tick1(); chk("R5 first tick", 32'(irq), 4'b0011);
    tick1(); chk("R5 second tick", 32'(irq), 4'b0001);
    wr(ta(0, 'h010), 0);

    // R5: overflow enable alone is not cleared, so timer 1 keeps firing
    wr(ta(1, 'h010), 32'd1 << MB_OVFE);
    tick1(); chk("R5 ovfe tick 1", 32'(irq), 4'b0010);
    tick1(); chk("R5 ovfe tick 2", 32'(irq), 4'b0010);
    wr(ta(1, 'h010), 0);

    // R7: count write in a tick cycle wins over zero return
    wr(ta(2, 'h010), (32'd1 << MB_CUE) | (32'd1 << MB_CMPE) | (32'd1 << MB_ZRET));
    addr = ta(2, 'h000); wdata = 32'h77; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R7 tick still fires", 32'(irq), 4'b0100);
    rd(ta(2, 'h000), v); chk("R7 count write wins", v, 32'h77);

    // R7: mode write in a firing tick cycle wins over the one-shot clear
    wr(ta(3, 'h010), 32'd1 << MB_CMPE);
    addr = ta(3, 'h010); wdata = (32'd1 << MB_CMPE) | (32'd1 << MB_OVFF) | 32'd1;
    wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R7 firing with mode write", 32'(irq), 4'b1000);
    rd(ta(3, 'h010), v);
    chk("R7 mode write wins", v, (32'd1 << MB_CMPE) | (32'd1 << MB_OVFF) | 32'd1);

    // R1: reset clears state again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", 32'(irq), 0);
    rd(ta(3, 'h010), v); chk("R1 mode after reset", v, 0);
    rd(ta(0, 'h030), v); chk("R1 hold after reset", v, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule